// File: doc/BRIEF.md
# Branch Decode and Next-PC Unit

This unit takes one 32-bit instruction word together with the current 64-bit program counter, two general-register operand values and an 8-bit vector of condition flags. It recognises whether the word is one of the supported branch or jump forms. It then resolves the taken decision, computes the following PC and works out any link-register write. It also presents, from the word it was given, the register indices and the flag index it needs, so that the surrounding pipeline can fetch the operands.

Inputs are captured when the input strobe is high. The results appear registered one cycle later, qualified by an output valid flag. A word that is not a branch advances the PC by four and requests no write.

Top module: `br_nextpc`

## Requirements
- R1: Decode uses the six most significant bits [31:26]. 0x10 means branch when the operand in `src_a` is zero, 0x11 means branch when it is nonzero, 0x13 is an indirect jump with link, 0x14 is unconditional, 0x15 is a call, and 0x16 to 0x1B are equal, not-equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. Opcode 0x12 with bits [9:8]=00 branches when the selected flag is zero, and with [9:8]=01 when it is nonzero. Every other word is a non-branch: `o_is_br`=0, `o_taken`=0, next PC = PC+4, and no link write.
- R2: Source index A is taken from bits [9:5], source index B from bits [4:0], and the flag index from bits [7:5]. All three are driven combinationally from `i_inst`.
- R3: The zero-test and flag branches use a 21-bit offset, with bits [4:0] as its high part and bits [25:10] as its low part. The offset is shifted left by 2 and sign-extended from bit 22.
- R4: The unconditional and call forms use a 26-bit offset, with bits [9:0] as its high part and bits [25:10] as its low part. The offset is shifted left by 2 and sign-extended from bit 27.
- R5: The compare branches and the indirect jump use bits [25:10], shifted left by 2 and sign-extended from bit 17.
- R6: A taken branch targets PC + offset. A not-taken branch targets PC + 4. The indirect jump targets `src_a` + offset and is always taken, as are the unconditional and call forms.
- R7: The signed compares treat the operands as two's-complement 64-bit values. The unsigned compares treat them as unsigned.
- R8: The indirect jump writes PC+4 to the register named by bits [4:0]. The call writes PC+4 to register 1. A link write whose target index is 0 is suppressed, so `o_lnk_we`=0.
- R9: A synchronous active-high reset clears `o_vld`. The outputs update only on cycles where `i_vld` is high, and `o_vld` follows `i_vld` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_vld | input | 1 | Input strobe |
| i_inst | input | 32 | Instruction word |
| i_pc | input | 64 | Current PC |
| i_src_a | input | 64 | Value of the register named by src index A |
| i_src_b | input | 64 | Value of the register named by src index B |
| i_flags | input | 8 | Condition flag vector |
| o_idx_a | output | 5 | Source register index A |
| o_idx_b | output | 5 | Source register index B |
| o_flag_idx | output | 3 | Condition flag index |
| o_vld | output | 1 | Result valid |
| o_is_br | output | 1 | Word was a branch or jump |
| o_taken | output | 1 | Control transfer taken |
| o_npc | output | 64 | Next PC |
| o_lnk_we | output | 1 | Link write enable |
| o_lnk_idx | output | 5 | Link destination register |
| o_lnk_val | output | 64 | Link value (PC+4) |

## Verification
Assertions check the following on every cycle: the output valid tracks the input strobe, a non-branch result never carries a taken flag or a write, a link write never targets register 0, and a not-taken result always lands on PC+4. The offset reassembly, the sign extension, the signed and unsigned compare boundaries and the register-relative jump target can only be shown by the bench. The bench sweeps every opcode with operand and offset corner values and compares the results against arithmetic computed in the bench.

// File: rtl/br_nextpc.sv
module br_nextpc (
  input  logic        clk,
  input  logic        rst,
  input  logic        i_vld,
  input  logic [31:0] i_inst,
  input  logic [63:0] i_pc,
  input  logic [63:0] i_src_a,
  input  logic [63:0] i_src_b,
  input  logic [7:0]  i_flags,
  output logic [4:0]  o_idx_a,
  output logic [4:0]  o_idx_b,
  output logic [2:0]  o_flag_idx,
  output logic        o_vld,
  output logic        o_is_br,
  output logic        o_taken,
  output logic [63:0] o_npc,
  output logic        o_lnk_we,
  output logic [4:0]  o_lnk_idx,
  output logic [63:0] o_lnk_val
);
  logic [5:0]  op;
  logic [63:0] off21, off26, off16, seq_pc, tgt;
  logic        is_br, taken, lnk_we, s_lt, u_lt, flag;
  logic [4:0]  lnk_idx;

  assign op         = i_inst[31:26];
  assign o_idx_a    = i_inst[9:5];
  assign o_idx_b    = i_inst[4:0];
  assign o_flag_idx = i_inst[7:5];
  assign flag       = i_flags[i_inst[7:5]];

  assign off21 = {{41{i_inst[4]}}, i_inst[4:0], i_inst[25:10], 2'b00};
  assign off26 = {{36{i_inst[9]}}, i_inst[9:0], i_inst[25:10], 2'b00};
  assign off16 = {{46{i_inst[25]}}, i_inst[25:10], 2'b00};

  assign seq_pc = i_pc + 64'd4;
  assign u_lt   = i_src_a < i_src_b;
  assign s_lt   = $signed(i_src_a) < $signed(i_src_b);

  always_comb begin
    is_br   = 1'b1;
    taken   = 1'b0;
    tgt     = i_pc + off16;
    lnk_we  = 1'b0;
    lnk_idx = 5'd0;
    case (op)
      6'h10: begin taken = (i_src_a == 64'd0); tgt = i_pc + off21; end
      6'h11: begin taken = (i_src_a != 64'd0); tgt = i_pc + off21; end
      6'h12: begin
        tgt = i_pc + off21;
        if (i_inst[9:8] == 2'b00)      taken = ~flag;
        else if (i_inst[9:8] == 2'b01) taken = flag;
        else                           is_br = 1'b0;
      end
      6'h13: begin
        taken = 1'b1; tgt = i_src_a + off16;
        lnk_idx = i_inst[4:0]; lnk_we = (i_inst[4:0] != 5'd0);
      end
      6'h14: begin taken = 1'b1; tgt = i_pc + off26; end
      6'h15: begin
        taken = 1'b1; tgt = i_pc + off26;
        lnk_idx = 5'd1; lnk_we = 1'b1;
      end
      6'h16: taken = (i_src_a == i_src_b);
      6'h17: taken = (i_src_a != i_src_b);
      6'h18: taken = s_lt;
      6'h19: taken = ~s_lt;
      6'h1A: taken = u_lt;
      6'h1B: taken = ~u_lt;
      default: is_br = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) o_vld <= 1'b0;
    else     o_vld <= i_vld;
  end

  always_ff @(posedge clk) begin
    if (i_vld) begin
      o_is_br   <= is_br;
      o_taken   <= taken;
      o_npc     <= taken ? tgt : seq_pc;
      o_lnk_we  <= lnk_we;
      o_lnk_idx <= lnk_idx;
      o_lnk_val <= seq_pc;
    end
  end

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    i_vld |=> o_vld);
  // R1
  nonbr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (o_vld && !o_is_br) |-> (!o_taken && !o_lnk_we));
  // R8
  no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    (o_vld && o_lnk_we) |-> (o_lnk_idx != 5'd0));
  // R6
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (i_vld && !taken) |=> (o_npc == $past(i_pc) + 64'd4));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (o_vld && !i_vld) |=> $stable(o_npc));
endmodule

// File: tb/br_nextpc_tb.sv
module br_nextpc_tb_top;
  logic clk = 0, rst = 1, i_vld = 0;
  logic [31:0] i_inst = 0;
  logic [63:0] i_pc = 0, i_src_a = 0, i_src_b = 0;
  logic [7:0]  i_flags = 0;
  logic [4:0]  o_idx_a, o_idx_b, o_lnk_idx;
  logic [2:0]  o_flag_idx;
  logic        o_vld, o_is_br, o_taken, o_lnk_we;
  logic [63:0] o_npc, o_lnk_val;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  br_nextpc dut_i (.*);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [63:0] pc, a, b,
                     input logic [7:0] f, input logic eb, et,
                     input logic [63:0] enpc, input logic ewe, input logic [4:0] eidx);
    @(negedge clk);
    i_inst = w; i_pc = pc; i_src_a = a; i_src_b = b; i_flags = f; i_vld = 1;
    #1;
    chk("R2 idx_a", 64'(o_idx_a), 64'(w[9:5]));
    chk("R2 idx_b", 64'(o_idx_b), 64'(w[4:0]));
    chk("R2 flag_idx", 64'(o_flag_idx), 64'(w[7:5]));
    @(negedge clk);
    i_vld = 0;
    chk("R9 vld", 64'(o_vld), 64'd1);
    chk("R1 is_br", 64'(o_is_br), 64'(eb));
    chk("R6 taken", 64'(o_taken), 64'(et));
    chk("R6 npc", o_npc, enpc);
    chk("R8 we", 64'(o_lnk_we), 64'(ewe));
    if (ewe) begin
      chk("R8 idx", 64'(o_lnk_idx), 64'(eidx));
      chk("R8 val", o_lnk_val, pc + 64'd4);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [15:0] lo, input logic [9:0] hi);
    return {op, lo, hi};
  endfunction

  initial begin
    logic [63:0] pc, o21, o26, o16, a, b;
    logic [63:0] vals [4];
    vals[0] = 64'd0; vals[1] = 64'd5;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF; vals[3] = 64'h8000_0000_0000_0000;
    pc = 64'h0000_0000_1000_0000;
    repeat (2) @(negedge clk);
    chk("R9 reset vld", 64'(o_vld), 64'd0);
    rst = 0;
    // R3 R4 R5 offsets with positive and negative high parts
    for (int s = 0; s < 2; s++) begin
      logic [15:0] lo; logic [9:0] hi;
      lo = s ? 16'h8001 : 16'h1234;
      hi = s ? 10'h3F0 : 10'h005;
      o21 = 64'($signed({hi[4:0], lo, 2'b00}));
      o26 = 64'($signed({hi, lo, 2'b00}));
      o16 = 64'($signed({lo, 2'b00}));
      // R3 zero tests
      run(mk(6'h10, lo, hi), pc, 0, 0, 0, 1, 1, pc + o21, 0, 0);
      run(mk(6'h10, lo, hi), pc, 7, 0, 0, 1, 0, pc + 4, 0, 0);
      run(mk(6'h11, lo, hi), pc, 7, 0, 0, 1, 1, pc + o21, 0, 0);
      run(mk(6'h11, lo, hi), pc, 0, 0, 0, 1, 0, pc + 4, 0, 0);
      // R4 unconditional / call
      run(mk(6'h14, lo, hi), pc, 0, 0, 0, 1, 1, pc + o26, 0, 0);
      run(mk(6'h15, lo, hi), pc, 0, 0, 0, 1, 1, pc + o26, 1, 5'd1);
      // R5 R6 R8 indirect jump
      run(mk(6'h13, lo, hi), pc, 64'h4000, 0, 0, 1, 1, 64'h4000 + o16, hi[4:0] != 0, hi[4:0]);
    end
    // R8 indirect jump to r0 suppressed
    run(mk(6'h13, 16'h0010, 10'h000), pc, 64'h100, 0, 0, 1, 1, 64'h140, 0, 0);
    // R3 flag branches, all 8 flags
    for (int k = 0; k < 8; k++) begin
      logic [9:0] h0, h1; logic [7:0] f;
      f = 8'hA5;
      h0 = {2'b00, 3'(k), 5'h01};
      h1 = {2'b01, 3'(k), 5'h01};
      o21 = 64'($signed({5'h01, 16'h0002, 2'b00}));
      run(mk(6'h12, 16'h0002, h0), pc, 0, 0, f, 1, !f[k], f[k] ? pc + 4 : pc + o21, 0, 0);
      run(mk(6'h12, 16'h0002, h1), pc, 0, 0, f, 1, f[k], f[k] ? pc + o21 : pc + 4, 0, 0);
    end
    // R1 flag opcode with bits[9:8]=1x is non-branch
    run(mk(6'h12, 16'h0002, 10'h200), pc, 0, 0, 8'hFF, 0, 0, pc + 4, 0, 0);
    // R7 compares over operand pairs
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        a = vals[i]; b = vals[j];
        o16 = 64'($signed({16'hFFF0, 2'b00}));
        run(mk(6'h16, 16'hFFF0, 10'h0), pc, a, b, 0, 1, a == b, a == b ? pc + o16 : pc + 4, 0, 0);
        run(mk(6'h17, 16'hFFF0, 10'h0), pc, a, b, 0, 1, a != b, a != b ? pc + o16 : pc + 4, 0, 0);
        run(mk(6'h18, 16'hFFF0, 10'h0), pc, a, b, 0, 1, $signed(a) < $signed(b),
            ($signed(a) < $signed(b)) ? pc + o16 : pc + 4, 0, 0);
        run(mk(6'h19, 16'hFFF0, 10'h0), pc, a, b, 0, 1, $signed(a) >= $signed(b),
            ($signed(a) >= $signed(b)) ? pc + o16 : pc + 4, 0, 0);
        run(mk(6'h1A, 16'hFFF0, 10'h0), pc, a, b, 0, 1, a < b, a < b ? pc + o16 : pc + 4, 0, 0);
        run(mk(6'h1B, 16'hFFF0, 10'h0), pc, a, b, 0, 1, a >= b, a >= b ? pc + o16 : pc + 4, 0, 0);
      end
    // R1 every non-branch opcode
    for (int op = 0; op < 64; op++)
      if (op < 16 || op > 27)
        run(mk(6'(op), 16'hFFFF, 10'h3FF), pc, 0, 0, 8'hFF, 0, 0, pc + 4, 0, 0);
    // R9 hold when idle
    a = o_npc;
    @(negedge clk); i_pc = 64'h55; i_inst = mk(6'h14, 16'h1, 10'h0);
    @(negedge clk);
    chk("R9 idle vld", 64'(o_vld), 64'd0);
    chk("R9 idle hold", o_npc, a);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule